// File: doc/BRIEF.md
# Horizontal Drive Pulse Sequencer

The sequencer produces a line-rate drive pulse from the system clock. The high time and the low time of each pulse are whole clock cycles. The nominal high time and the nominal low time come from configuration inputs. The drive never jumps between off and full duty. On the way up the high time climbs by a fixed step at every period boundary, and on the way down it falls by the same step. The low time always stays at its nominal value.

From standby, a start-up request opens a low-power phase. In this phase the high time climbs from zero to roughly 30% of nominal and then holds there. It leaves the phase only when three things are true: the block is commanded on, the main supply reports ready, and the configuration has been received. It then continues the ramp to nominal from the level it was holding.

On and standby are selected by a two-bit command. A command counts only when both bits have changed. A flyback watcher counts period boundaries that pass without a flyback edge and raises a sticky alarm.

Top module: `hdrive_seq`

## Requirements
- R1: After reset `drive_o` is 0, `miss_fb_o` is 0 and `state_o` is 0. While `state_o` stays 0, the drive stays low.
- R2: The block keeps a reference copy of `stby_i`, which is 2'b00 after reset. When both bits of `stby_i` differ from the reference, the on/standby request toggles and the reference takes the new value. When only one bit differs, nothing changes.
- R3: An on request in standby starts a ramp-up. The first period has a high time of 0. After that the high time grows by STEP at each period end and saturates at `ton_nom_i`. Once it reaches nominal, the state becomes run and the high time tracks `ton_nom_i`.
- R4: Every period, including every ramp period, has a low time of `toff_nom_i` cycles.
- R5: A standby request in run or ramp-up starts a ramp-down. The high time drops by STEP at each period end. The period that runs with a high time of STEP or less is the last one. After it the state is standby and no more pulses appear.
- R6: A start-up request `lp_start_i` in standby with no on request starts the low-power phase. The high time grows from 0 by STEP per period and saturates at (`ton_nom_i` × 77) >> 8.
- R7: The low-power phase ends only at a period end where the on request, `supply_ok_i` and `cfg_rx_i` are all 1. The ramp-up then continues from the held high time.
- R8: `miss_fb_o` rises after three period ends have passed with no rising flyback edge, while the drive runs. Any flyback edge restarts the count.
- R9: `miss_fb_o` stays set until `miss_clr_i` is high for one cycle. That strobe clears both the flag and the count.
- R10: The `state_o` encoding is 0 standby, 1 low-power start-up, 2 ramp-up, 3 run and 4 ramp-down. No other value ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ton_nom_i | input | CNT_W | Nominal high time in cycles |
| toff_nom_i | input | CNT_W | Nominal low time in cycles |
| lp_start_i | input | 1 | Low-power start-up request |
| supply_ok_i | input | 1 | Main supply ready |
| cfg_rx_i | input | 1 | Configuration received |
| stby_i | input | 2 | Two-bit on/standby command |
| flyback_i | input | 1 | Flyback pulse, asynchronous |
| miss_clr_i | input | 1 | Clear strobe for the missing-flyback flag |
| drive_o | output | 1 | Drive pulse |
| miss_fb_o | output | 1 | Missing-flyback flag, sticky |
| state_o | output | 3 | Sequencer state |

## Verification
The bench measures every high pulse and compares its width against a queue of expected widths. Any extra pulse counts as a failure, so it also catches a drive that fails to stop.

The stimulus covers five patterns:
- A ramp-up from standby, where the nominal value is a multiple of the step. This separates saturation from overshoot.
- A low-power start where the 30% target is not a multiple of the step. This exposes a wrong target and a wrong hold.
- Single-bit and two-bit command changes. These separate the guarded handshake from a plain level decode.
- A flyback train that is stopped, then cleared, then resumed. This pins the alarm to the third missing period and shows that the flag stays set.
- A ramp-down ending in silence. This confirms the last period and the return to standby.

// File: rtl/hdrive_pkg.sv
package hdrive_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_LP   = 3'd1,
    ST_UP   = 3'd2,
    ST_RUN  = 3'd3,
    ST_DOWN = 3'd4
  } hd_state_e;
endpackage

// File: rtl/hdrive_stby_guard.sv
module hdrive_stby_guard (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] stby_i,
  output logic       on_req_o
);
  logic [1:0] ref_q;
  logic       on_q;

  // only a change of both bits against the last accepted value counts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 2'b00;
      on_q  <= 1'b0;
    end else if (stby_i == ~ref_q) begin
      ref_q <= stby_i;
      on_q  <= ~on_q;
    end
  end

  assign on_req_o = on_q;
endmodule

// File: rtl/hdrive_pulse_gen.sv
module hdrive_pulse_gen #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] ton_i,
  input  logic [CNT_W-1:0] toff_i,
  output logic             drive_o,
  output logic             line_end_o
);
  localparam int PW = CNT_W + 1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] per;
  logic          drive_q;

  assign per        = {1'b0, ton_i} + {1'b0, toff_i};
  assign line_end_o = en_i && ((cnt_q + PW'(1)) >= per);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      drive_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      drive_q <= 1'b0;
    end else begin
      cnt_q   <= line_end_o ? '0 : cnt_q + PW'(1);
      drive_q <= (cnt_q < {1'b0, ton_i});
    end
  end

  assign drive_o = drive_q;
endmodule

// File: rtl/hdrive_ramp_ctrl.sv
module hdrive_ramp_ctrl
  import hdrive_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int STEP     = 4,
  parameter int LP_NUM   = 77,
  parameter int LP_SHIFT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_end_i,
  input  logic             on_req_i,
  input  logic             lp_req_i,
  input  logic             supply_ok_i,
  input  logic             cfg_rx_i,
  input  logic [CNT_W-1:0] ton_nom_i,
  output hd_state_e        state_o,
  output logic [CNT_W-1:0] ton_o
);
  localparam int              MW     = CNT_W + LP_SHIFT;
  localparam logic [CNT_W:0]  STEP_W = (CNT_W+1)'(STEP);

  hd_state_e        state_q, state_d;
  logic [CNT_W-1:0] ton_q, ton_d;
  logic [MW-1:0]    lp_prod;
  logic [CNT_W-1:0] lp_tgt;

  assign lp_prod = {{LP_SHIFT{1'b0}}, ton_nom_i} * MW'(LP_NUM);
  assign lp_tgt  = CNT_W'(lp_prod >> LP_SHIFT);

  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] lim);
    logic [CNT_W:0] s;
    s = {1'b0, a} + STEP_W;
    return (s >= {1'b0, lim}) ? lim : CNT_W'(s);
  endfunction

  function automatic logic [CNT_W-1:0] step_dn(input logic [CNT_W-1:0] a);
    return ({1'b0, a} > STEP_W) ? CNT_W'({1'b0, a} - STEP_W) : '0;
  endfunction

  always_comb begin
    state_d = state_q;
    ton_d   = ton_q;
    unique case (state_q)
      ST_OFF: begin
        ton_d = '0;
        if (on_req_i)      state_d = ST_UP;
        else if (lp_req_i) state_d = ST_LP;
      end
      ST_LP: if (line_end_i) begin
        if (on_req_i && supply_ok_i && cfg_rx_i) begin
          state_d = ST_UP;
          ton_d   = step_up(ton_q, ton_nom_i);
        end else begin
          ton_d   = step_up(ton_q, lp_tgt);
        end
      end
      ST_UP: if (line_end_i) begin
        if (!on_req_i) begin
          ton_d   = step_dn(ton_q);
          state_d = (ton_d == '0) ? ST_OFF : ST_DOWN;
        end else begin
          ton_d = step_up(ton_q, ton_nom_i);
          if (ton_d == ton_nom_i) state_d = ST_RUN;
        end
      end
      ST_RUN: if (line_end_i) begin
        if (!on_req_i) begin
          ton_d   = step_dn(ton_q);
          state_d = (ton_d == '0) ? ST_OFF : ST_DOWN;
        end else begin
          ton_d = ton_nom_i;
        end
      end
      ST_DOWN: if (line_end_i) begin
        if (on_req_i) begin
          state_d = ST_UP;
          ton_d   = step_up(ton_q, ton_nom_i);
        end else if ({1'b0, ton_q} <= STEP_W) begin
          state_d = ST_OFF;
          ton_d   = '0;
        end else begin
          ton_d = step_dn(ton_q);
        end
      end
      default: begin
        state_d = ST_OFF;
        ton_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      ton_q   <= '0;
    end else begin
      state_q <= state_d;
      ton_q   <= ton_d;
    end
  end

  assign state_o = state_q;
  assign ton_o   = ton_q;
endmodule

// File: rtl/hdrive_fb_watch.sv
module hdrive_fb_watch #(
  parameter int MISS_LINES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line_end_i,
  input  logic flyback_i,
  input  logic clr_i,
  output logic miss_o
);
  localparam int CW = $clog2(MISS_LINES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   fb_edge;
  logic [CW-1:0]          cnt_q;
  logic                   miss_q;

  assign fb_edge = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], flyback_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      if (!en_i || fb_edge)                                cnt_q <= '0;
      else if (line_end_i && cnt_q < CW'(MISS_LINES))      cnt_q <= cnt_q + CW'(1);
      miss_q <= miss_q | (cnt_q == CW'(MISS_LINES));
    end
  end

  assign miss_o = miss_q;
endmodule

// File: rtl/hdrive_seq.sv
module hdrive_seq
  import hdrive_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int STEP        = 4,
  parameter int MISS_LINES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] ton_nom_i,
  input  logic [CNT_W-1:0] toff_nom_i,
  input  logic             lp_start_i,
  input  logic             supply_ok_i,
  input  logic             cfg_rx_i,
  input  logic [1:0]       stby_i,
  input  logic             flyback_i,
  input  logic             miss_clr_i,
  output logic             drive_o,
  output logic             miss_fb_o,
  output logic [2:0]       state_o
);
  logic             on_req;
  logic             line_end;
  logic             running;
  logic [CNT_W-1:0] ton_cur;
  hd_state_e        state;

  assign running = (state != ST_OFF);
  assign state_o = state;

  hdrive_stby_guard u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stby_i   (stby_i),
    .on_req_o (on_req)
  );

  hdrive_ramp_ctrl #(
    .CNT_W (CNT_W),
    .STEP  (STEP)
  ) u_ramp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_end_i  (line_end),
    .on_req_i    (on_req),
    .lp_req_i    (lp_start_i),
    .supply_ok_i (supply_ok_i),
    .cfg_rx_i    (cfg_rx_i),
    .ton_nom_i   (ton_nom_i),
    .state_o     (state),
    .ton_o       (ton_cur)
  );

  hdrive_pulse_gen #(
    .CNT_W (CNT_W)
  ) u_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (running),
    .ton_i      (ton_cur),
    .toff_i     (toff_nom_i),
    .drive_o    (drive_o),
    .line_end_o (line_end)
  );

  hdrive_fb_watch #(
    .MISS_LINES  (MISS_LINES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_fb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (running),
    .line_end_i (line_end),
    .flyback_i  (flyback_i),
    .clr_i      (miss_clr_i),
    .miss_o     (miss_fb_o)
  );
endmodule

// File: rtl/hdrive_seq_chk.sv
module hdrive_seq_chk
  import hdrive_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic       cfg_rx_i,
  input logic       miss_clr_i,
  input logic       drive_o,
  input logic       miss_fb_o,
  input logic [2:0] state_o
);
  localparam logic [2:0] S_OFF  = 3'(ST_OFF);
  localparam logic [2:0] S_LP   = 3'(ST_LP);
  localparam logic [2:0] S_UP   = 3'(ST_UP);
  localparam logic [2:0] S_RUN  = 3'(ST_RUN);
  localparam logic [2:0] S_DOWN = 3'(ST_DOWN);

  a_r1_drive_low_in_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_OFF && $past(state_o) == S_OFF) |-> !drive_o);

  a_r10_state_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= S_DOWN);

  a_r2_off_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == S_OFF |=> (state_o == S_OFF || state_o == S_LP || state_o == S_UP));

  a_r5_run_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == S_RUN |=> (state_o == S_RUN || state_o == S_DOWN || state_o == S_OFF));

  a_r7_lp_exit_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_UP && $past(state_o) == S_LP) |-> $past(supply_ok_i && cfg_rx_i));

  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_fb_o && !miss_clr_i) |=> miss_fb_o);

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_clr_i |=> !miss_fb_o);
endmodule

bind hdrive_seq hdrive_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_ok_i (supply_ok_i),
  .cfg_rx_i    (cfg_rx_i),
  .miss_clr_i  (miss_clr_i),
  .drive_o     (drive_o),
  .miss_fb_o   (miss_fb_o),
  .state_o     (state_o)
);

// File: tb/tb_hdrive_seq.sv
module tb_hdrive_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int STEP       = 8;
  localparam int TON        = 40;
  localparam int TOFF       = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] ton_nom = CNT_W'(TON);
  logic [CNT_W-1:0] toff_nom = CNT_W'(TOFF);
  logic             lp_start = 1'b0;
  logic             supply_ok = 1'b0;
  logic             cfg_rx = 1'b0;
  logic [1:0]       stby = 2'b00;
  logic             flyback = 1'b0;
  logic             miss_clr = 1'b0;
  logic             drive_o;
  logic             miss_fb_o;
  logic [2:0]       state_o;

  int n_chk = 0;
  int n_err = 0;
  int exp_w[$];
  string exp_tag[$];
  int hi_len = 0, lo_len = 0, last_low = 0;
  int fb_dly = 0, fb_w = 0;
  bit prev_drv = 1'b0;
  bit fb_en = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdrive_seq #(.CNT_W(CNT_W), .STEP(STEP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ton_nom_i(ton_nom), .toff_nom_i(toff_nom),
    .lp_start_i(lp_start), .supply_ok_i(supply_ok), .cfg_rx_i(cfg_rx),
    .stby_i(stby), .flyback_i(flyback), .miss_clr_i(miss_clr),
    .drive_o(drive_o), .miss_fb_o(miss_fb_o), .state_o(state_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int w, input string tag);
    exp_w.push_back(w);
    exp_tag.push_back(tag);
  endtask

  task automatic wait_empty();
    while (exp_w.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: measures pulses, pops and compares; also emits flyback after each fall
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        hi_len = 0; lo_len = 0; prev_drv = 1'b0; flyback = 1'b0;
        continue;
      end
      if (drive_o) begin
        if (!prev_drv) begin
          last_low = lo_len;
          lo_len = 0;
        end
        hi_len++;
      end else begin
        if (prev_drv) begin
          if (exp_w.size() == 0) begin
            n_chk++; n_err++;
            $display("FAIL R5 unexpected pulse actual=%0d expected=none", hi_len);
          end else begin
            int w;
            string t;
            w = exp_w.pop_front();
            t = exp_tag.pop_front();
            chk(hi_len == w, t, hi_len, w);
          end
          hi_len = 0;
          fb_dly = 3;
        end
        lo_len++;
      end
      prev_drv = drive_o;
      if (fb_dly > 0) begin
        fb_dly--;
        if (fb_dly == 0) fb_w = 4;
      end
      flyback = (fb_w > 0) && fb_en;
      if (fb_w > 0) fb_w--;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(drive_o == 1'b0, "R1 drive", int'(drive_o), 0);
    chk(miss_fb_o == 1'b0, "R1 miss", int'(miss_fb_o), 0);
    chk(state_o == 3'd0, "R1 state", int'(state_o), 0);

    // R3 soft start from standby
    push(8, "R3"); push(16, "R3"); push(24, "R3"); push(32, "R3");
    push(40, "R3"); push(40, "R3"); push(40, "R3");
    stby = 2'b11;
    wait_empty();
    chk(state_o == 3'd3, "R10 run", int'(state_o), 3);
    chk(last_low == TOFF, "R4 low time", last_low, TOFF);
    chk(miss_fb_o == 1'b0, "R8 flyback present", int'(miss_fb_o), 0);

    // R2 single bit flips ignored
    stby = 2'b10;
    push(40, "R2"); push(40, "R2"); push(40, "R2");
    wait_empty();
    chk(state_o == 3'd3, "R2 one bit", int'(state_o), 3);
    stby = 2'b11;
    push(40, "R2"); push(40, "R2");
    wait_empty();

    // R8 flyback lost
    fb_en = 1'b0;
    push(40, "R8");
    wait_empty();
    chk(miss_fb_o == 1'b0, "R8 two misses", int'(miss_fb_o), 0);
    push(40, "R8");
    wait_empty();
    chk(miss_fb_o == 1'b1, "R8 three misses", int'(miss_fb_o), 1);

    // R9 sticky, clear restarts count
    push(40, "R9");
    wait_empty();
    chk(miss_fb_o == 1'b1, "R9 sticky", int'(miss_fb_o), 1);
    miss_clr = 1'b1;
    @(negedge clk);
    miss_clr = 1'b0;
    @(negedge clk);
    chk(miss_fb_o == 1'b0, "R9 cleared", int'(miss_fb_o), 0);
    push(40, "R9"); push(40, "R9");
    wait_empty();
    chk(miss_fb_o == 1'b0, "R9 recount", int'(miss_fb_o), 0);
    push(40, "R9");
    wait_empty();
    chk(miss_fb_o == 1'b1, "R9 reset again", int'(miss_fb_o), 1);
    fb_en = 1'b1;
    push(40, "R9"); push(40, "R9");
    wait_empty();
    miss_clr = 1'b1;
    @(negedge clk);
    miss_clr = 1'b0;
    push(40, "R9"); push(40, "R9"); push(40, "R9"); push(40, "R9");
    wait_empty();
    chk(miss_fb_o == 1'b0, "R9 resumed", int'(miss_fb_o), 0);

    // R5 soft stop
    stby = 2'b00;
    push(32, "R5"); push(24, "R5"); push(16, "R5"); push(8, "R5");
    wait_empty();
    repeat (200) @(negedge clk);
    chk(state_o == 3'd0, "R5 standby", int'(state_o), 0);
    chk(drive_o == 1'b0, "R1 off low", int'(drive_o), 0);

    // R2 single bit in standby
    stby = 2'b01;
    repeat (150) @(negedge clk);
    chk(state_o == 3'd0, "R2 one bit standby", int'(state_o), 0);
    stby = 2'b00;
    @(negedge clk);

    // R6 low-power start: target (40*77)>>8 = 12
    lp_start = 1'b1;
    push(8, "R6"); push(12, "R6"); push(12, "R6"); push(12, "R6");
    wait_empty();
    chk(state_o == 3'd1, "R10 lp", int'(state_o), 1);

    // R7 held while configuration missing
    supply_ok = 1'b1;
    stby = 2'b11;
    push(12, "R7"); push(12, "R7");
    wait_empty();
    chk(state_o == 3'd1, "R7 hold", int'(state_o), 1);
    cfg_rx = 1'b1;
    push(20, "R7"); push(28, "R7"); push(36, "R7"); push(40, "R7"); push(40, "R7");
    wait_empty();
    chk(state_o == 3'd3, "R7 run", int'(state_o), 3);
    chk(last_low == TOFF, "R4 low after lp", last_low, TOFF);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule